// File: doc/BRIEF.md
# AXI4-Lite Register Bank Slave

This block is a small AXI4-Lite slave that holds a fixed set of 32-bit registers in a window that starts at a parameterised base address. Each register has its own access kind. A status word mirrors a user-logic input and is read-only. A configuration word can be read and written, and it pulses a strobe whenever the bus writes it. A packed field word carries a go bit, an arm bit and an 8-bit level in fixed bit positions. A command word is write-only and pulses its own strobe. A 64-bit counter input is read as two consecutive words.

The write address and write data channels are taken independently and combined before the register is updated. One write and one read can be in flight at the same time. Reads of the low counter word capture the high half, so software reading low then high sees one coherent 64-bit sample.

When `SYNC_EN` is set, the register outputs are moved into a separate user clock domain through `SYNC_STAGES`-deep flip-flop chains. The strobes cross as toggles that are edge-detected on the user side. The status and counter inputs are resynchronised into the bus clock through chains of the same depth.

Top module: `regbank_axil`

## Requirements
- R1: Write address and write data are accepted independently (`s_awready`/`s_wready` high while the matching slot is empty); the register update and `s_bvalid` occur on the clock edge after both are held, and `s_bvalid` with `s_bresp` stays stable until `s_bready`.
- R2: Word offset is (address − base) with the low two address bits ignored; offsets 0x00 to 0x14 are mapped and give response OKAY (2'b00), and every other address gives SLVERR (2'b10) and changes no register.
- R3: A read is accepted while `s_rvalid` is low (`s_arready` = not `s_rvalid`); data and response appear on the next edge and are held stable until `s_rready`.
- R4: A read of an unmapped address returns data 0 with response SLVERR.
- R5: Offset 0x00 is read-only and returns `stat_i`; writes to it are acknowledged OKAY and have no effect.
- R6: Offset 0x04 is read-write and drives `cfg_o`; only byte lanes with the matching `s_wstrb` bit set change.
- R7: Offset 0x08 is read-write with fields go at bit 0 (`fld_go_o`), arm at bit 4 (`fld_arm_o`) and level at bits 15:8 (`fld_lvl_o`); all other bits read as 0 and are not stored; byte strobes apply.
- R8: Offset 0x0C is write-only: it drives `cmd_o` with byte strobes applied and always reads as 0.
- R9: `cfg_wr_o` (offset 0x04) and `cmd_wr_o` (offset 0x0C) are high for exactly one cycle on every OKAY write to that word, in the cycle the new value is first visible on the output.
- R10: Offset 0x10 returns `cnt_i[31:0]` and captures `cnt_i[63:32]` at that same read; offset 0x14 returns the captured high half.
- R11: Reset clears all writable registers, the captured high half, all strobes and both response valids.
- R12: With `SYNC_EN` set, `cfg_o`, the field outputs, `cmd_o` and the two strobes appear `SYNC_STAGES` user-clock edges later than without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Bus-domain reset, active low, asynchronous |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| usr_clk | input | 1 | User-domain clock (used when SYNC_EN is set) |
| usr_rst_n | input | 1 | User-domain reset, active low |
| stat_i | input | 32 | Status value shown at offset 0x00 |
| cnt_i | input | 64 | Counter value shown at offsets 0x10/0x14 |
| cfg_o | output | 32 | Configuration word |
| cfg_wr_o | output | 1 | Configuration write pulse |
| fld_go_o | output | 1 | Go field |
| fld_arm_o | output | 1 | Arm field |
| fld_lvl_o | output | 8 | Level field |
| cmd_o | output | 32 | Command word |
| cmd_wr_o | output | 1 | Command write pulse |

## Verification
Writes are driven with address before data, data before address and both together, which separates a slave that needs both channels in one cycle from one that holds each side on its own. Partial byte strobes on the configuration and field words show whether lane merging is done against the old value. Writes and reads aimed at the read-only, write-only, unmapped and out-of-window addresses show whether decode and access kind are kept apart. A low-then-high counter read with the counter changed in between shows whether the high half comes from the capture or from the live input. A second instance built with a three-stage user-domain path runs on the same stimulus, and its outputs are compared with the model delayed by three cycles.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned STRB_W    = DATA_W / 8;
    localparam int unsigned NUM_WORDS = 6;
    localparam int unsigned CNT_W     = 2 * DATA_W;

    // word index (offset / 4); the counter halves must stay adjacent, low first
    typedef enum logic [2:0] {
        W_STAT   = 3'd0,
        W_CFG    = 3'd1,
        W_FLD    = 3'd2,
        W_CMD    = 3'd3,
        W_CNT_LO = 3'd4,
        W_CNT_HI = 3'd5
    } word_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    // packed field word layout
    localparam int unsigned FLD_GO_BIT  = 0;
    localparam int unsigned FLD_ARM_BIT = 4;
    localparam int unsigned FLD_LVL_LSB = 8;
    localparam int unsigned FLD_LVL_W   = 8;
    localparam int unsigned FLD_PACK_W  = FLD_LVL_W + 2;
    localparam logic [DATA_W-1:0] FLD_MASK =
        (DATA_W'(1) << FLD_GO_BIT) | (DATA_W'(1) << FLD_ARM_BIT) |
        (DATA_W'((1 << FLD_LVL_W) - 1) << FLD_LVL_LSB);

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] lanes
    );
        logic [DATA_W-1:0] r;
        for (int i = 0; i < STRB_W; i++) begin
            r[8*i +: 8] = lanes[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/regbank_sync.sv
module regbank_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/regbank_toggle_rx.sv
module regbank_toggle_rx #(
    parameter int unsigned STAGES = 2
) (
    input  logic dst_clk,
    input  logic dst_rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    logic tgl_s;
    logic prev_q;

    regbank_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (tgl_i),
        .q     (tgl_s)
    );

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) prev_q <= 1'b0;
        else            prev_q <= tgl_s;
    end

    assign pulse_o = tgl_s ^ prev_q;
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h1000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output word_e             word
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * 4);

    logic [ADDR_W-1:0] off;
    logic [1:0]        unused_byte_sel;

    assign off             = addr - BASE_ADDR;
    assign hit             = off < SPAN;
    assign word            = word_e'(off[4:2]);
    assign unused_byte_sel = off[1:0];
endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
    import regbank_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h1000,
    parameter bit                SYNC_EN     = 1'b0,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    input  logic              usr_clk,
    input  logic              usr_rst_n,
    input  logic [31:0]       stat_i,
    input  logic [63:0]       cnt_i,
    output logic [31:0]       cfg_o,
    output logic              cfg_wr_o,
    output logic              fld_go_o,
    output logic              fld_arm_o,
    output logic [7:0]        fld_lvl_o,
    output logic [31:0]       cmd_o,
    output logic              cmd_wr_o
);

    typedef struct packed {
        logic              aw_full;
        logic [ADDR_W-1:0] aw_addr;
        logic              w_full;
        logic [DATA_W-1:0] w_data;
        logic [STRB_W-1:0] w_strb;
        logic              bvalid;
        logic [1:0]        bresp;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic [1:0]        rresp;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] fld;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] cnt_hi;
        logic              cfg_wr;
        logic              cmd_wr;
        logic              cfg_tgl;
        logic              cmd_tgl;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0]     stat_v;
    logic [CNT_W-1:0]      cnt_v;
    logic                  wr_hit, rd_hit;
    word_e                 wr_word, rd_word;
    logic                  commit;
    logic [FLD_PACK_W-1:0] fld_pack, fld_pack_u;

    regbank_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wr_dec (
        .addr (st_q.aw_addr),
        .hit  (wr_hit),
        .word (wr_word)
    );

    regbank_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd_dec (
        .addr (s_araddr),
        .hit  (rd_hit),
        .word (rd_word)
    );

    assign commit = st_q.aw_full && st_q.w_full && !st_q.bvalid;

    always_comb begin
        st_d        = st_q;
        st_d.cfg_wr = 1'b0;
        st_d.cmd_wr = 1'b0;

        // write response retires
        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;

        // channel capture, each on its own
        if (s_awvalid && !st_q.aw_full) begin
            st_d.aw_full = 1'b1;
            st_d.aw_addr = s_awaddr;
        end
        if (s_wvalid && !st_q.w_full) begin
            st_d.w_full = 1'b1;
            st_d.w_data = s_wdata;
            st_d.w_strb = s_wstrb;
        end

        // combine and update
        if (commit) begin
            st_d.aw_full = 1'b0;
            st_d.w_full  = 1'b0;
            st_d.bvalid  = 1'b1;
            st_d.bresp   = wr_hit ? RESP_OKAY : RESP_SLVERR;
            if (wr_hit) begin
                case (wr_word)
                    W_CFG: begin
                        st_d.cfg     = merge_lanes(st_q.cfg, st_q.w_data, st_q.w_strb);
                        st_d.cfg_wr  = 1'b1;
                        st_d.cfg_tgl = ~st_q.cfg_tgl;
                    end
                    W_FLD: begin
                        st_d.fld = merge_lanes(st_q.fld, st_q.w_data, st_q.w_strb) & FLD_MASK;
                    end
                    W_CMD: begin
                        st_d.cmd     = merge_lanes(st_q.cmd, st_q.w_data, st_q.w_strb);
                        st_d.cmd_wr  = 1'b1;
                        st_d.cmd_tgl = ~st_q.cmd_tgl;
                    end
                    default: ;
                endcase
            end
        end

        // read path
        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
        if (s_arvalid && !st_q.rvalid) begin
            st_d.rvalid = 1'b1;
            st_d.rresp  = rd_hit ? RESP_OKAY : RESP_SLVERR;
            st_d.rdata  = '0;
            if (rd_hit) begin
                case (rd_word)
                    W_STAT:   st_d.rdata = stat_v;
                    W_CFG:    st_d.rdata = st_q.cfg;
                    W_FLD:    st_d.rdata = st_q.fld;
                    W_CNT_LO: begin
                        st_d.rdata  = cnt_v[DATA_W-1:0];
                        st_d.cnt_hi = cnt_v[CNT_W-1:DATA_W];
                    end
                    W_CNT_HI: st_d.rdata = st_q.cnt_hi;
                    default:  st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge aclk or negedge aresetn) begin
        if (!aresetn) st_q <= '0;
        else          st_q <= st_d;
    end

    assign s_awready = !st_q.aw_full;
    assign s_wready  = !st_q.w_full;
    assign s_bvalid  = st_q.bvalid;
    assign s_bresp   = st_q.bresp;
    assign s_arready = !st_q.rvalid;
    assign s_rvalid  = st_q.rvalid;
    assign s_rdata   = st_q.rdata;
    assign s_rresp   = st_q.rresp;

    assign fld_pack = {st_q.fld[FLD_LVL_LSB +: FLD_LVL_W], st_q.fld[FLD_ARM_BIT], st_q.fld[FLD_GO_BIT]};

    generate
        if (SYNC_EN) begin : g_cdc
            regbank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_stat_s (
                .clk (aclk), .rst_n (aresetn), .d (stat_i), .q (stat_v)
            );
            regbank_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_s (
                .clk (aclk), .rst_n (aresetn), .d (cnt_i), .q (cnt_v)
            );
            regbank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_cfg_s (
                .clk (usr_clk), .rst_n (usr_rst_n), .d (st_q.cfg), .q (cfg_o)
            );
            regbank_sync #(.WIDTH(FLD_PACK_W), .STAGES(SYNC_STAGES)) u_fld_s (
                .clk (usr_clk), .rst_n (usr_rst_n), .d (fld_pack), .q (fld_pack_u)
            );
            regbank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_cmd_s (
                .clk (usr_clk), .rst_n (usr_rst_n), .d (st_q.cmd), .q (cmd_o)
            );
            regbank_toggle_rx #(.STAGES(SYNC_STAGES)) u_cfg_p (
                .dst_clk (usr_clk), .dst_rst_n (usr_rst_n),
                .tgl_i (st_q.cfg_tgl), .pulse_o (cfg_wr_o)
            );
            regbank_toggle_rx #(.STAGES(SYNC_STAGES)) u_cmd_p (
                .dst_clk (usr_clk), .dst_rst_n (usr_rst_n),
                .tgl_i (st_q.cmd_tgl), .pulse_o (cmd_wr_o)
            );
        end else begin : g_direct
            logic unused_usr;
            assign unused_usr = usr_clk ^ usr_rst_n;
            assign stat_v     = stat_i;
            assign cnt_v      = cnt_i;
            assign cfg_o      = st_q.cfg;
            assign fld_pack_u = fld_pack;
            assign cmd_o      = st_q.cmd;
            assign cfg_wr_o   = st_q.cfg_wr;
            assign cmd_wr_o   = st_q.cmd_wr;
        end
    endgenerate

    assign fld_go_o  = fld_pack_u[0];
    assign fld_arm_o = fld_pack_u[1];
    assign fld_lvl_o = fld_pack_u[FLD_PACK_W-1:2];

endmodule

// File: rtl/regbank_axil_chk.sv
module regbank_axil_chk
    import regbank_pkg::*;
#(
    parameter bit SYNC_EN = 1'b0
) (
    input logic        aclk,
    input logic        aresetn,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic [1:0]  s_bresp,
    input logic        s_arready,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata,
    input logic [1:0]  s_rresp,
    input logic        cfg_wr_o,
    input logic        cmd_wr_o
);

    a_r1_bresp_held: assert property (@(posedge aclk) disable iff (!aresetn)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));

    a_r3_rdata_held: assert property (@(posedge aclk) disable iff (!aresetn)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));

    a_r3_one_read: assert property (@(posedge aclk) disable iff (!aresetn)
        s_rvalid |-> !s_arready);

    a_r4_err_zero: assert property (@(posedge aclk) disable iff (!aresetn)
        s_rvalid && (s_rresp == RESP_SLVERR) |-> s_rdata == '0);

    a_r11_reset_idle: assert property (@(posedge aclk)
        !aresetn |-> !s_bvalid && !s_rvalid);

    generate
        if (!SYNC_EN) begin : g_pulse
            a_r9_cfg_with_resp: assert property (@(posedge aclk) disable iff (!aresetn)
                cfg_wr_o |-> s_bvalid && (s_bresp == RESP_OKAY));
            a_r9_cfg_single: assert property (@(posedge aclk) disable iff (!aresetn)
                cfg_wr_o |=> !cfg_wr_o);
            a_r9_cmd_with_resp: assert property (@(posedge aclk) disable iff (!aresetn)
                cmd_wr_o |-> s_bvalid && (s_bresp == RESP_OKAY));
            a_r9_cmd_single: assert property (@(posedge aclk) disable iff (!aresetn)
                cmd_wr_o |=> !cmd_wr_o);
        end
    endgenerate

endmodule

bind regbank_axil regbank_axil_chk #(.SYNC_EN(SYNC_EN)) u_chk (
    .aclk      (aclk),
    .aresetn   (aresetn),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp),
    .s_arready (s_arready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp),
    .cfg_wr_o  (cfg_wr_o),
    .cmd_wr_o  (cmd_wr_o)
);

// File: tb/regbank_axil_tb_top.sv
`timescale 1ns/1ps
module regbank_axil_tb_top;

    localparam logic [15:0] BASE = 16'h1000;
    localparam logic [31:0] FMASK = 32'h0000_FF11;
    localparam int DLY = 3;

    logic aclk = 1'b0;
    logic aresetn = 1'b0;
    always #2.5 aclk = ~aclk;

    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [15:0] awaddr = 0, araddr = 0;
    logic [31:0] wdata = 0, stat_i = 0;
    logic [3:0]  wstrb = 0;
    logic [63:0] cnt_i = 0;

    logic        awready, wready, bvalid, arready, rvalid, cfg_wr, go, arm, cmd_wr;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata, cfg, cmd;
    logic [7:0]  lvl;

    logic        x_awready, x_wready, x_bvalid, x_arready, x_rvalid, x_cfg_wr, x_go, x_arm, x_cmd_wr;
    logic [1:0]  x_bresp, x_rresp;
    logic [31:0] x_rdata, x_cfg, x_cmd;
    logic [7:0]  x_lvl;

    regbank_axil #(.ADDR_W(16), .BASE_ADDR(BASE)) dut_i (
        .aclk(aclk), .aresetn(aresetn),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
        .usr_clk(aclk), .usr_rst_n(aresetn), .stat_i(stat_i), .cnt_i(cnt_i),
        .cfg_o(cfg), .cfg_wr_o(cfg_wr), .fld_go_o(go), .fld_arm_o(arm), .fld_lvl_o(lvl),
        .cmd_o(cmd), .cmd_wr_o(cmd_wr)
    );

    regbank_axil #(.ADDR_W(16), .BASE_ADDR(BASE), .SYNC_EN(1'b1), .SYNC_STAGES(DLY)) dut_sync_i (
        .aclk(aclk), .aresetn(aresetn),
        .s_awvalid(awvalid), .s_awready(x_awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(x_wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(x_bvalid), .s_bready(bready), .s_bresp(x_bresp),
        .s_arvalid(arvalid), .s_arready(x_arready), .s_araddr(araddr),
        .s_rvalid(x_rvalid), .s_rready(rready), .s_rdata(x_rdata), .s_rresp(x_rresp),
        .usr_clk(aclk), .usr_rst_n(aresetn), .stat_i(stat_i), .cnt_i(cnt_i),
        .cfg_o(x_cfg), .cfg_wr_o(x_cfg_wr), .fld_go_o(x_go), .fld_arm_o(x_arm), .fld_lvl_o(x_lvl),
        .cmd_o(x_cmd), .cmd_wr_o(x_cmd_wr)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] awq[$];
    logic [31:0] wq_d[$];
    logic [3:0]  wq_s[$];
    logic [31:0] m_cfg = 0, m_fld = 0, m_cmd = 0, m_hi = 0, m_rdata = 0;
    logic        m_cfg_wr = 0, m_cmd_wr = 0, m_bvalid = 0, m_rvalid = 0;
    logic [1:0]  m_bresp = 0, m_rresp = 0;
    string       m_rtag = "R3";
    logic [31:0] h_cfg[DLY+1];
    logic        h_cfg_wr[DLY+1];
    logic [31:0] h_cmd[DLY+1];
    logic        h_cmd_wr[DLY+1];

    function automatic int mword(input logic [15:0] a);
        int o = int'(a) - int'(BASE);
        if (o < 0 || o >= 24) return -1;
        return o / 4;
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic model_reset();
        awq.delete(); wq_d.delete(); wq_s.delete();
        m_cfg = 0; m_fld = 0; m_cmd = 0; m_hi = 0; m_rdata = 0;
        m_cfg_wr = 0; m_cmd_wr = 0; m_bvalid = 0; m_rvalid = 0; m_bresp = 0; m_rresp = 0;
        for (int k = 0; k <= DLY; k++) begin
            h_cfg[k] = 0; h_cfg_wr[k] = 0; h_cmd[k] = 0; h_cmd_wr[k] = 0;
        end
    endtask

    task automatic compare(input bit in_rst);
        string t1 = in_rst ? "R11" : "R1";
        string t3 = in_rst ? "R11" : "R3";
        chk(t1, "awready", awready, awq.size() == 0);
        chk(t1, "wready", wready, wq_d.size() == 0);
        chk(t1, "bvalid", bvalid, m_bvalid);
        chk(in_rst ? "R11" : "R2", "bresp", bresp, m_bresp);
        chk(t3, "arready", arready, !m_rvalid);
        chk(t3, "rvalid", rvalid, m_rvalid);
        chk(in_rst ? "R11" : m_rtag, "rdata", rdata, m_rdata);
        chk(in_rst ? "R11" : "R4", "rresp", rresp, m_rresp);
        chk(in_rst ? "R11" : "R6", "cfg_o", cfg, m_cfg);
        chk(in_rst ? "R11" : "R7", "fld_go", go, m_fld[0]);
        chk(in_rst ? "R11" : "R7", "fld_arm", arm, m_fld[4]);
        chk(in_rst ? "R11" : "R7", "fld_lvl", lvl, m_fld[15:8]);
        chk(in_rst ? "R11" : "R8", "cmd_o", cmd, m_cmd);
        chk(in_rst ? "R11" : "R9", "cfg_wr", cfg_wr, m_cfg_wr);
        chk(in_rst ? "R11" : "R9", "cmd_wr", cmd_wr, m_cmd_wr);
        for (int k = DLY; k > 0; k--) begin
            h_cfg[k] = h_cfg[k-1]; h_cfg_wr[k] = h_cfg_wr[k-1];
            h_cmd[k] = h_cmd[k-1]; h_cmd_wr[k] = h_cmd_wr[k-1];
        end
        h_cfg[0] = m_cfg; h_cfg_wr[0] = m_cfg_wr; h_cmd[0] = m_cmd; h_cmd_wr[0] = m_cmd_wr;
        chk("R12", "sync cfg_o", x_cfg, h_cfg[DLY]);
        chk("R12", "sync cfg_wr", x_cfg_wr, h_cfg_wr[DLY]);
        chk("R12", "sync cmd_o", x_cmd, h_cmd[DLY]);
        chk("R12", "sync cmd_wr", x_cmd_wr, h_cmd_wr[DLY]);
    endtask

    task automatic step();
        bit aw_hs = awvalid && (awq.size() == 0);
        bit w_hs  = wvalid && (wq_d.size() == 0);
        bit do_commit = (awq.size() != 0) && (wq_d.size() != 0) && !m_bvalid;
        bit rd_hs = arvalid && !m_rvalid;
        m_cfg_wr = 0;
        m_cmd_wr = 0;
        if (rvalid && rready && m_rvalid) m_rvalid = 0;
        if (rd_hs) begin
            int w = mword(araddr);
            m_rvalid = 1;
            m_rresp  = (w < 0) ? 2'b10 : 2'b00;
            case (w)
                0: begin m_rdata = stat_i; m_rtag = "R5"; end
                1: begin m_rdata = m_cfg; m_rtag = "R6"; end
                2: begin m_rdata = m_fld; m_rtag = "R7"; end
                3: begin m_rdata = 0; m_rtag = "R8"; end
                4: begin m_rdata = cnt_i[31:0]; m_hi = cnt_i[63:32]; m_rtag = "R10"; end
                5: begin m_rdata = m_hi; m_rtag = "R10"; end
                default: begin m_rdata = 0; m_rtag = "R4"; end
            endcase
        end
        if (m_bvalid && bready) m_bvalid = 0;
        if (do_commit) begin
            logic [15:0] a = awq.pop_front();
            logic [31:0] d = wq_d.pop_front();
            logic [3:0]  s = wq_s.pop_front();
            int w = mword(a);
            m_bvalid = 1;
            m_bresp  = (w < 0) ? 2'b10 : 2'b00;
            case (w)
                1: begin m_cfg = lanes(m_cfg, d, s); m_cfg_wr = 1; end
                2: m_fld = lanes(m_fld, d, s) & FMASK;
                3: begin m_cmd = lanes(m_cmd, d, s); m_cmd_wr = 1; end
                default: ;
            endcase
        end
        if (aw_hs) awq.push_back(awaddr);
        if (w_hs) begin wq_d.push_back(wdata); wq_s.push_back(wstrb); end
    endtask

    always @(negedge aclk) begin
        if (!aresetn) begin
            model_reset();
            compare(1'b1);
        end else begin
            compare(1'b0);
            step();
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge aclk); #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s,
                      input int aw_dly, input int w_dly, input int b_dly);
        bit aw_done = 0;
        bit w_done = 0;
        awaddr = a; wdata = d; wstrb = s;
        for (int c = 0; !(aw_done && w_done); c++) begin
            awvalid = (c >= aw_dly) && !aw_done;
            wvalid  = (c >= w_dly) && !w_done;
            @(negedge aclk);
            if (awvalid && awready) aw_done = 1;
            if (wvalid && wready) w_done = 1;
            tick();
        end
        awvalid = 0; wvalid = 0;
        for (int c = 0; c < b_dly; c++) tick();
        bready = 1;
        forever begin
            @(negedge aclk);
            if (bvalid) break;
            tick();
        end
        tick();
        bready = 0;
    endtask

    task automatic rd(input logic [15:0] a, input int r_dly);
        araddr = a; arvalid = 1;
        forever begin
            @(negedge aclk);
            if (arready) break;
            tick();
        end
        tick();
        arvalid = 0;
        for (int c = 0; c < r_dly; c++) tick();
        rready = 1;
        forever begin
            @(negedge aclk);
            if (rvalid) break;
            tick();
        end
        tick();
        rready = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge aclk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge aclk);
        #1 aresetn = 1;
        stat_i = 32'hA5A5_0F0F;
        cnt_i  = 64'h0000_0002_FFFF_FFF0;
        tick();
        rd(BASE + 16'h00, 0);                               // R5
        wr(BASE + 16'h04, 32'h1234_5678, 4'hF, 0, 0, 0);    // R6 R9
        rd(BASE + 16'h04, 0);
        wr(BASE + 16'h04, 32'hAABB_CCDD, 4'b0010, 3, 0, 0); // R1 data first, R6 lane
        rd(BASE + 16'h04, 3);                               // R3 held read
        wr(BASE + 16'h08, 32'hFFFF_FFFF, 4'hF, 0, 2, 0);    // R1 addr first, R7
        rd(BASE + 16'h08, 0);
        wr(BASE + 16'h08, 32'h0000_0000, 4'b0001, 0, 0, 0); // R7 lane 0 only
        rd(BASE + 16'h08, 0);
        wr(BASE + 16'h0C, 32'hDEAD_BEEF, 4'hF, 1, 1, 3);    // R8 R9, R1 held resp
        rd(BASE + 16'h0C, 0);                               // R8 reads zero
        wr(BASE + 16'h0C, 32'h0000_0077, 4'b1001, 0, 0, 0);
        wr(BASE + 16'h00, 32'hFFFF_FFFF, 4'hF, 0, 0, 0);    // R5 write ignored
        stat_i = 32'h0BAD_F00D;
        rd(BASE + 16'h00, 0);
        wr(BASE + 16'h18, 32'h1111_1111, 4'hF, 0, 0, 0);    // R2 past window
        wr(16'h0FFC, 32'h2222_2222, 4'hF, 0, 0, 2);         // R2 below base
        rd(BASE + 16'h18, 0);                               // R4
        rd(16'h0FFC, 1);                                    // R4
        rd(BASE + 16'h10, 0);                               // R10 low captures high
        cnt_i = 64'h0000_0007_0000_0001;
        rd(BASE + 16'h14, 0);                               // R10 high from capture
        rd(BASE + 16'h10, 0);
        rd(BASE + 16'h14, 0);
        wr(BASE + 16'h06, 32'h0F0F_0F0F, 4'hF, 0, 0, 0);    // R2 low bits ignored
        fork
            wr(BASE + 16'h04, 32'h5555_AAAA, 4'b1100, 2, 0, 1);
            rd(BASE + 16'h04, 2);
        join
        fork
            wr(BASE + 16'h0C, 32'h0000_0001, 4'hF, 0, 0, 0);
            rd(BASE + 16'h08, 0);
        join
        rd(BASE + 16'h04, 0);
        repeat (DLY + 2) tick();
        aresetn = 0;                                        // R11 mid-run reset
        repeat (3) tick();
        aresetn = 1;
        rd(BASE + 16'h14, 0);                               // R11 captured half cleared
        rd(BASE + 16'h04, 0);
        repeat (DLY + 3) tick();
        finish_run();
    end

endmodule